// File: doc/BRIEF.md
# Clock Divider Transition Sequencer

This block moves a processor clock from one divide ratio to another: 1, 2, 4, 6 or 8. It never writes the new ratio in one step. It breaks each change into an ordered list of register actions on two outputs. The first output is the divider select code, which feeds the clock generator. The second is a memory control word. That word carries a self-refresh enable bit and a refresh count field, which a memory controller uses. The block waits a timed interval wherever the clock or the memory needs time to settle.

A request enters on a valid/ready pair. `req_ready` is high only while the block is idle. There is no back-pressure beyond that: a request offered while the block is busy is not taken and has no effect. Each taken request ends with a one-cycle `done` pulse. An illegal index ends with `err` held high. The base clock frequency is a parameter. The refresh counts for all ratios are computed from it at elaboration. All wait intervals are counted in base clock cycles.

Top module: `clkdiv_seq`

## Requirements
- R1: `div_sel` carries only legal codes: 0 for divide-by-1, 1 for divide-by-2, 3 for divide-by-4, 2 for divide-by-6 and 4 for divide-by-8. Request indices 0, 1, 2, 3 and 4 select ratios 1, 2, 4, 6 and 8 in that order.
- R2: `mem_ctl` bit 16 is the self-refresh enable. Bits 14:8 hold the refresh count. All other bits are zero. The count written for ratio d is floor(BASE_CLK_HZ × 7800 / (64 × d × 10^9)).
- R3: Stepping from divide-by-2 to divide-by-1 clears self-refresh first, then writes the divider, then writes the new refresh count.
- R4: Stepping from divide-by-1 to divide-by-2 writes the new refresh count first, then writes the divider, then sets self-refresh.
- R5: A change between divide-by-1 and divide-by-4, 6 or 8, in either direction, runs as two steps through divide-by-2. `div_sel` never changes directly between code 0 and codes 2, 3 or 4.
- R6: In any other step to a larger ratio, the refresh count is written before the divider. In a step to a smaller ratio, the divider is written first and the refresh count after it.
- R7: After every divider write, no further output change occurs for at least 16 cycles.
- R8: When a step raises the ratio while self-refresh is off, the divider write waits at least 64 × (old count + new count) × old ratio cycles after the count write.
- R9: A request for the ratio already in effect causes no output change and still ends with `done`.
- R10: A request index above 4 causes no output change. It ends with `done` and `err` high. `err` stays high until the next request is taken.
- R11: `busy` is high and `req_ready` is low from the cycle after acceptance until the sequence ends. Requests offered while busy are ignored. `done` is high for exactly one cycle.
- R12: After reset the block is at divide-by-1 with self-refresh off, the divide-by-1 refresh count in place, and `busy`, `done` and `err` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A new ratio request is offered |
| req_ready | output | 1 | High when a request can be taken (idle) |
| req_idx | input | 3 | Requested ratio index, legal values 0 to 4 |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a request has finished |
| err | output | 1 | The last request had an illegal index |
| div_sel | output | 3 | Divider select code for the clock generator |
| mem_ctl | output | 17 | Memory control word: self-refresh at bit 16, refresh count at bits 14:8 |

## Verification
The assertions assume that reset is held low for at least one edge before any request is made. They also assume that `req_idx` matters only in the cycle where `req_valid` meets `req_ready`. The stimulus holds `req_valid` for a single idle cycle. It then offers unrelated requests only while `busy` is high, and withdraws them in the same cycle that `done` appears, so a stray request is never taken by accident. The scoreboard builds the expected order of writes and the minimum gaps between them from the ordering rules alone. Each change it sees on `div_sel` or `mem_ctl` is matched against that list.

// File: rtl/clkdiv_seq_pkg.sv
package clkdiv_seq_pkg;

  localparam int unsigned IDX_W      = 3;
  localparam int unsigned NUM_RATIOS = 5;
  localparam int unsigned CODE_W     = 3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PLAN,
    ST_SREF_OFF,
    ST_CNT,
    ST_DRAIN,
    ST_DIV,
    ST_PLL,
    ST_SREF_ON
  } seq_state_e;

  // Select code driven to the clock generator for each ratio index.
  function automatic logic [CODE_W-1:0] idx_to_code(input logic [IDX_W-1:0] idx);
    logic [CODE_W-1:0] c;
    case (idx)
      3'd0:    c = 3'd0;
      3'd1:    c = 3'd1;
      3'd2:    c = 3'd3;
      3'd3:    c = 3'd2;
      3'd4:    c = 3'd4;
      default: c = 3'd0;
    endcase
    return c;
  endfunction

  // Divide ratio for each ratio index.
  function automatic logic [3:0] idx_to_ratio(input logic [IDX_W-1:0] idx);
    logic [3:0] r;
    case (idx)
      3'd0:    r = 4'd1;
      3'd1:    r = 4'd2;
      3'd2:    r = 4'd4;
      3'd3:    r = 4'd6;
      3'd4:    r = 4'd8;
      default: r = 4'd1;
    endcase
    return r;
  endfunction

  // Refresh count for one refresh per interval, at a given clock rate.
  function automatic int unsigned refresh_count(input longint unsigned hz,
                                                input int unsigned     ns,
                                                input int unsigned     clks,
                                                input int unsigned     ratio,
                                                input int unsigned     cnt_max);
    longint unsigned q;
    q = (hz * 64'(ns)) / (64'(clks) * 64'(ratio) * 64'd1_000_000_000);
    if (q > 64'(cnt_max)) q = 64'(cnt_max);
    return 32'(q);
  endfunction

endpackage

// File: rtl/clkdiv_refresh_table.sv
module clkdiv_refresh_table
  import clkdiv_seq_pkg::*;
#(
  parameter longint unsigned BASE_CLK_HZ   = 500_000_000,
  parameter int unsigned     REFRESH_NS    = 7800,
  parameter int unsigned     CLKS_PER_UNIT = 64,
  parameter int unsigned     CNT_W         = 7
) (
  input  logic [IDX_W-1:0] idx,
  output logic [CNT_W-1:0] count
);
  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] tbl [NUM_RATIOS];

  for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_entry
    localparam int unsigned VAL = refresh_count(BASE_CLK_HZ, REFRESH_NS, CLKS_PER_UNIT,
                                                32'(idx_to_ratio(IDX_W'(i))), CNT_MAX);
    assign tbl[i] = CNT_W'(VAL);
  end

  always_comb begin
    count = '0;
    for (int k = 0; k < NUM_RATIOS; k++) begin
      if (idx == IDX_W'(k)) count = tbl[k];
    end
  end
endmodule

// File: rtl/clkdiv_step_planner.sv
module clkdiv_step_planner
  import clkdiv_seq_pkg::*;
(
  input  logic [IDX_W-1:0] cur_idx,
  input  logic [IDX_W-1:0] tgt_idx,
  output logic [IDX_W-1:0] step_idx,
  output logic             step_rise
);
  logic via_half;

  // Full speed and deep divides never meet directly: route through index 1.
  always_comb begin
    via_half  = ((cur_idx == 3'd0) && (tgt_idx > 3'd1)) ||
                ((cur_idx > 3'd1) && (tgt_idx == 3'd0));
    step_idx  = via_half ? 3'd1 : tgt_idx;
    step_rise = step_idx > cur_idx;
  end
endmodule

// File: rtl/clkdiv_wait_timer.sv
module clkdiv_wait_timer #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expired
);
  logic [W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             left_q <= '0;
    else if (load)          left_q <= len;
    else if (left_q != '0)  left_q <= left_q - 1'b1;
  end

  assign expired = (left_q <= W'(1));

  // R8: a loaded interval starts at its full length
  a_r8_timer_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (left_q == $past(len)));
endmodule

// File: rtl/clkdiv_seq.sv
module clkdiv_seq
  import clkdiv_seq_pkg::*;
#(
  parameter longint unsigned BASE_CLK_HZ     = 500_000_000,
  parameter int unsigned     PLL_LOCK_CYCLES = 16,
  parameter int unsigned     REFRESH_NS      = 7800,
  parameter int unsigned     CLKS_PER_UNIT   = 64,
  parameter int unsigned     CNT_W           = 7,
  parameter int unsigned     CNT_LSB         = 8,
  parameter int unsigned     SREF_BIT        = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [IDX_W-1:0]    req_idx,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic [CODE_W-1:0]   div_sel,
  output logic [SREF_BIT:0]   mem_ctl
);
  localparam int unsigned MCTL_W  = SREF_BIT + 1;
  localparam int unsigned RATIO_W = 4;
  localparam int unsigned DRAIN_W = CNT_W + 1 + $clog2(CLKS_PER_UNIT) + RATIO_W;
  localparam int unsigned PLL_W   = $clog2(PLL_LOCK_CYCLES + 1);
  localparam int unsigned TMR_W   = (DRAIN_W > PLL_W) ? DRAIN_W : PLL_W;
  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;
  localparam logic [CNT_W-1:0] RESET_CNT =
    CNT_W'(refresh_count(BASE_CLK_HZ, REFRESH_NS, CLKS_PER_UNIT, 1, CNT_MAX));

  seq_state_e        state_q;
  logic [IDX_W-1:0]  cur_q, tgt_q, step_q, prev_q;
  logic              bad_q, rise_q, sref_q, done_q, err_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] div_q;

  logic [IDX_W-1:0]  plan_step;
  logic              plan_rise;
  logic [CNT_W-1:0]  new_cnt;
  logic              tmr_load, tmr_expired;
  logic [TMR_W-1:0]  tmr_len, drain_len;

  clkdiv_step_planner u_planner (
    .cur_idx   (cur_q),
    .tgt_idx   (tgt_q),
    .step_idx  (plan_step),
    .step_rise (plan_rise)
  );

  clkdiv_refresh_table #(
    .BASE_CLK_HZ   (BASE_CLK_HZ),
    .REFRESH_NS    (REFRESH_NS),
    .CLKS_PER_UNIT (CLKS_PER_UNIT),
    .CNT_W         (CNT_W)
  ) u_table (
    .idx   (step_q),
    .count (new_cnt)
  );

  clkdiv_wait_timer #(.W(TMR_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .len     (tmr_len),
    .expired (tmr_expired)
  );

  // Drain interval: both counts must run out at the old clock rate.
  always_comb begin
    drain_len = (TMR_W'(cnt_q) + TMR_W'(new_cnt)) * TMR_W'(CLKS_PER_UNIT)
                * TMR_W'(idx_to_ratio(cur_q));
  end

  always_comb begin
    tmr_load = 1'b0;
    tmr_len  = '0;
    if (state_q == ST_DIV) begin
      tmr_load = 1'b1;
      tmr_len  = TMR_W'(PLL_LOCK_CYCLES);
    end else if (state_q == ST_CNT && rise_q && !sref_q) begin
      tmr_load = 1'b1;
      tmr_len  = drain_len;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      tgt_q   <= '0;
      step_q  <= '0;
      prev_q  <= '0;
      bad_q   <= 1'b0;
      rise_q  <= 1'b0;
      sref_q  <= 1'b0;
      cnt_q   <= RESET_CNT;
      div_q   <= idx_to_code(3'd0);
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            tgt_q   <= req_idx;
            bad_q   <= (req_idx >= IDX_W'(NUM_RATIOS));
            err_q   <= 1'b0;
            state_q <= ST_PLAN;
          end
        end
        ST_PLAN: begin
          if (bad_q || cur_q == tgt_q) begin
            done_q  <= 1'b1;
            err_q   <= bad_q;
            state_q <= ST_IDLE;
          end else begin
            step_q <= plan_step;
            rise_q <= plan_rise;
            if (cur_q == 3'd1 && plan_step == 3'd0) state_q <= ST_SREF_OFF;
            else if (plan_rise)                     state_q <= ST_CNT;
            else                                    state_q <= ST_DIV;
          end
        end
        ST_SREF_OFF: begin
          sref_q  <= 1'b0;
          state_q <= ST_DIV;
        end
        ST_CNT: begin
          cnt_q <= new_cnt;
          if (rise_q) state_q <= sref_q ? ST_DIV : ST_DRAIN;
          else        state_q <= ST_PLAN;
        end
        ST_DRAIN: begin
          if (tmr_expired) state_q <= ST_DIV;
        end
        ST_DIV: begin
          div_q   <= idx_to_code(step_q);
          prev_q  <= cur_q;
          cur_q   <= step_q;
          state_q <= ST_PLL;
        end
        ST_PLL: begin
          if (tmr_expired) begin
            if (prev_q == 3'd0 && cur_q == 3'd1) state_q <= ST_SREF_ON;
            else if (!rise_q)                    state_q <= ST_CNT;
            else                                 state_q <= ST_PLAN;
          end
        end
        ST_SREF_ON: begin
          sref_q  <= 1'b1;
          state_q <= ST_PLAN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_ctl                          = '0;
    mem_ctl[SREF_BIT]                = sref_q;
    mem_ctl[CNT_LSB +: CNT_W]        = cnt_q;
  end

  assign busy      = (state_q != ST_IDLE);
  assign req_ready = (state_q == ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign div_sel   = div_q;

  // R1: only legal select codes reach the clock generator
  a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    div_q inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd4});

  // R5: leaving full speed always lands on divide-by-2
  a_r5_leave_full: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(div_q) == 3'd0 && div_q != 3'd0) |-> div_q == 3'd1);

  // R5: reaching full speed always comes from divide-by-2
  a_r5_reach_full: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(div_q) != 3'd0 && div_q == 3'd0) |-> $past(div_q) == 3'd1);

  // R3: self-refresh is never on while running at full speed
  a_r3_no_sref_at_full: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == 3'd0) |-> !sref_q);

  // R7: the memory word stays put right after a divider write
  a_r7_pll_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q != $past(div_q)) |=> ($stable(sref_q) && $stable(cnt_q)));

  // R11: done lasts one cycle
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R11: a request offered while busy leaves the target alone
  a_r11_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> $stable(tgt_q));
endmodule

// File: tb/clkdiv_seq_bench.sv
module clkdiv_seq_bench;
  localparam longint unsigned BASE = 500_000_000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_idx = 3'd0;
  logic        req_ready, busy, done, err;
  logic [2:0]  div_sel;
  logic [16:0] mem_ctl;

  clkdiv_seq #(.BASE_CLK_HZ(BASE)) u_clkdiv_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_idx(req_idx), .busy(busy), .done(done), .err(err),
    .div_sel(div_sel), .mem_ctl(mem_ctl)
  );

  always #5 clk = ~clk;

  // kind: 0 divider write, 1 self-refresh write, 2 refresh count write
  typedef struct {
    int    kind;
    int    val;
    int    min_gap;
    string tag;
  } item_t;

  item_t exp_q[$];
  int checks = 0, errors = 0, cyc = 0, last_evt = 0, last_kind = -1;
  int model_cur = 0;
  int p_div = 0, p_sref = 0, p_cnt = 0;

  function automatic int ratio_of(int i);
    case (i) 0: return 1; 1: return 2; 2: return 4; 3: return 6; default: return 8; endcase
  endfunction
  function automatic int code_of(int i);
    case (i) 0: return 0; 1: return 1; 2: return 3; 3: return 2; default: return 4; endcase
  endfunction
  function automatic int rc(int i);
    longint unsigned q;
    q = (BASE * 64'd7800) / (64'd64 * 64'(ratio_of(i)) * 64'd1_000_000_000);
    return int'(q);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(int kind, int val, int gap, string tag);
    item_t it;
    it.kind = kind; it.val = val; it.tag = tag;
    it.min_gap = (last_kind == 0 && gap < 16) ? 16 : gap;
    exp_q.push_back(it);
    last_kind = kind;
  endtask

  task automatic plan_expect(int tgt);
    int cur = model_cur;
    while (cur != tgt) begin
      int s = ((cur == 0 && tgt > 1) || (cur > 1 && tgt == 0)) ? 1 : tgt;
      if (cur == 1 && s == 0) begin
        push(1, 0, 0, "R3");
        push(0, code_of(0), 0, "R3");
        push(2, rc(0), 16, "R3");
      end else if (s > cur) begin
        push(2, rc(s), 0, (cur == 0) ? "R4" : "R6");
        if (cur == 0) begin
          push(0, code_of(s), 64 * (rc(cur) + rc(s)) * ratio_of(cur), "R8");
          push(1, 1, 16, "R4");
        end else begin
          push(0, code_of(s), 0, "R6");
        end
      end else begin
        push(0, code_of(s), 0, "R6");
        push(2, rc(s), 16, "R7");
      end
      cur = s;
    end
    model_cur = tgt;
  endtask

  task automatic on_event(int kind, int val);
    item_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, "R9", "unexpected output change, kind", kind, -1);
    end else begin
      e = exp_q.pop_front();
      check(e.kind == kind, e.tag, "write order kind", kind, e.kind);
      check(e.val == val, e.tag, "written value", val, e.val);
      check((cyc - last_evt) >= e.min_gap, (e.min_gap == 16) ? "R7" : e.tag,
            "gap before write", cyc - last_evt, e.min_gap);
    end
    last_evt = cyc;
  endtask

  // Monitor: compare every output change with the scoreboard.
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (int'(div_sel) != p_div) begin
        check((p_div != 0 || div_sel == 3'd1) && (div_sel != 3'd0 || p_div == 1),
              "R5", "divider jump skips divide-by-2", int'(div_sel), 1);
        on_event(0, int'(div_sel));
      end
      if (int'(mem_ctl[16]) != p_sref) on_event(1, int'(mem_ctl[16]));
      if (int'(mem_ctl[14:8]) != p_cnt) on_event(2, int'(mem_ctl[14:8]));
    end
    p_div  = int'(div_sel);
    p_sref = int'(mem_ctl[16]);
    p_cnt  = int'(mem_ctl[14:8]);
  end

  task automatic run_req(int idx, int stray);
    int n = 0;
    bit exp_err = (idx > 4);
    if (!exp_err) plan_expect(idx);
    @(negedge clk);
    req_valid = 1'b1; req_idx = 3'(idx);
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b1, "R11", "busy after acceptance", busy, 1);
    while (!done && n < 20000) begin
      if (busy && n < 3) begin
        check(req_ready == 1'b0, "R11", "ready while busy", req_ready, 0);
        req_valid = 1'b1; req_idx = 3'(stray);
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    check(done == 1'b1, "R11", "done seen", done, 1);
    check(err == exp_err, "R10", "err flag", err, exp_err);
    check(exp_q.size() == 0, exp_err ? "R10" : "R9", "writes left pending", exp_q.size(), 0);
    check(int'(div_sel) == code_of(model_cur), "R1", "final select code", div_sel, code_of(model_cur));
    check(int'(mem_ctl[14:8]) == rc(model_cur), "R2", "final refresh count", mem_ctl[14:8], rc(model_cur));
    check(mem_ctl[16] == (model_cur != 0), "R2", "final self-refresh", mem_ctl[16], model_cur != 0);
    check(mem_ctl[15] == 1'b0 && mem_ctl[7:0] == 8'd0, "R2", "unused word bits", mem_ctl, 0);
    @(negedge clk);
    check(done == 1'b0, "R11", "done one cycle", done, 0);
    check(err == exp_err, "R10", "err held", err, exp_err);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    check(div_sel == 3'd0, "R12", "reset select", div_sel, 0);
    check(int'(mem_ctl) == (rc(0) << 8), "R12", "reset memory word", mem_ctl, rc(0) << 8);
    check(!busy && !done && !err && req_ready, "R12", "reset handshake", {busy, done, err, req_ready}, 1);
    run_req(1, 4);  // R4: full to half speed with drain
    run_req(0, 3);  // R3: half to full speed
    run_req(4, 0);  // R5: full to divide-by-8 via divide-by-2
    run_req(2, 0);  // R6: falling ratio 8 to 4
    run_req(3, 1);  // R6: rising ratio 4 to 6
    run_req(3, 0);  // R9: same ratio
    run_req(0, 4);  // R5: divide-by-6 to full via divide-by-2
    run_req(6, 2);  // R10: illegal index
    run_req(7, 1);  // R10: illegal index
    run_req(2, 0);  // R5: full to divide-by-4
    run_req(1, 3);  // R6: falling ratio 4 to 2
    run_req(0, 2);  // R3
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R11", "watchdog expired", cyc, 0);
    finish_run();
  end
endmodule